// File: doc/BRIEF.md
# Dual-Polarity Reversible-Gate Binary Decoder

This block turns an N-bit code into 2^N decoded lines using only reversible gate primitives: a single-control inverter (Feynman), a two-target copier (double Feynman), a paired inverter (BVF) and a controlled swap (Fredkin). One mode line sets the output polarity. With it low, the selected line is 1 and all other lines are 0. With it high, the selected line is 0 and all other lines are 1. The mode line never blanks the outputs.

The structure has three parts. A first stage decodes code bit 0 into two complementary lines. After it, each higher code bit adds a rank of Fredkin gates. Each gate in a rank routes one incoming line to one of two outgoing lines and puts a copy of the mode line on the other. The select bit of a rank passes from gate to gate down the chain, and the mode line is copied by a chain of double Feynman gates ending in one Feynman gate, so no wire has a fan-out. The lines that leave the circuit unused are all brought out on one port. With the constant inputs added, the whole circuit can be checked as a reversible map. The block is purely combinational, and N may be 2, 3 or 4.

Top module: `dualpol_decoder`

## Requirements
- R1: With `pol_low` = 0, output `y` has exactly one bit set, and that bit's index is the value on `code`.
- R2: With `pol_low` = 1, output `y` has exactly one bit cleared, and that bit's index is the value on `code`. All other bits of `y` are 1.
- R3: `code` is an unsigned binary number whose most significant bit is `code[N-1]`. For example, with N = 3 and `pol_low` = 1, code 3'b011 clears `y[3]` and code 3'b000 clears `y[0]`.
- R4: The controlled-swap primitive maps (a,b,c) to (a, b, c) when a = 0 and to (a, c, b) when a = 1.
- R5: The paired-inverter primitive maps (a,b,c,d) to (a, a^b, c, c^d).
- R6: The single inverter maps (a,b) to (a, a^b). The two-target copier maps (a,b,c) to (a, a^b, a^c).
- R7: Every primitive is a bijection: its 2^k input vectors give 2^k distinct output vectors.
- R8: Over all 2^(N+1) combinations of `code` and `pol_low`, the pair {`y`, `junk`} takes 2^(N+1) distinct values. `junk` is N+2 bits wide, so the decoder loses no information.
- R9: The decoder behaves the same way, as set out in R1 to R3, for N = 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code | input | N | Binary code to decode, MSB at index N-1 |
| pol_low | input | 1 | 0: one-hot high outputs, 1: one-cold low outputs |
| y | output | 2^N | Decoded lines |
| junk | output | N+2 | Unused gate outputs brought out to show reversibility |

## Verification
The two functions that act together on every evaluation are the selection made by the code bits and the polarity made by the mode line. Each Fredkin gate handles both at once: its swap input selects, and its third input carries the mode-line copy that sets the level of every line not selected. The bench provokes this by driving every code with both polarities. It also drives random code and polarity pairs to all three sizes, including flips of polarity alone with the code held. Each case is judged by checking the whole output vector against a one-hot word XORed with the replicated mode line. Injectivity is judged separately over the full input space of each gate and of the complete decoder.

// File: rtl/rgd_pkg.sv
package rgd_pkg;
  localparam int unsigned MIN_BITS = 2;
  localparam int unsigned MAX_BITS = 4;

  // first line index of the stage that carries 2^k lines
  function automatic int unsigned stage_base(input int unsigned k);
    return (1 << k) - 2;
  endfunction

  // total decoded lines over all stages for n code bits
  function automatic int unsigned total_lines(input int unsigned n);
    return (1 << (n + 1)) - 2;
  endfunction
endpackage

// File: rtl/rgd_feynman.sv
module rgd_feynman (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
endmodule

// File: rtl/rgd_dfeynman.sv
module rgd_dfeynman (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = a ^ c;
endmodule

// File: rtl/rgd_bvf.sv
module rgd_bvf (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  assign p = a;
  assign q = a ^ b;
  assign r = c;
  assign s = c ^ d;
endmodule

// File: rtl/rgd_fredkin.sv
module rgd_fredkin (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ? c : b;
  assign r = a ? b : c;

  always_comb begin
    // R7
    swap_weight_chk: assert ($countones({p, q, r}) == $countones({a, b, c}))
      else $error("controlled swap changed the number of ones");
  end
endmodule

// File: rtl/rgd_copier.sv
module rgd_copier #(
  parameter int unsigned NC = 4
) (
  input  logic          src,
  output logic [NC-1:0] dup
);
  localparam int unsigned NG = NC / 2 - 1;

  logic [NG:0] pass;
  assign pass[0] = src;

  for (genvar i = 0; i < NG; i++) begin : g_tap
    rgd_dfeynman u_tap (
      .a(pass[i]), .b(1'b0), .c(1'b0),
      .p(pass[i+1]), .q(dup[2*i]), .r(dup[2*i+1])
    );
  end

  rgd_feynman u_tail (
    .a(pass[NG]), .b(1'b0),
    .p(dup[NC-2]), .q(dup[NC-1])
  );

  always_comb begin
    // R2
    copies_chk: assert (dup == {NC{src}})
      else $error("mode line copies disagree");
  end
endmodule

// File: rtl/rgd_core.sv
module rgd_core (
  input  logic       sel0,
  input  logic       m0,
  input  logic       m1,
  output logic [1:0] lines,
  output logic [2:0] waste
);
  logic s_pos, s_neg;

  rgd_dfeynman u_split (
    .a(sel0), .b(1'b0), .c(1'b1),
    .p(waste[0]), .q(s_pos), .r(s_neg)
  );

  rgd_bvf u_pol (
    .a(m0), .b(s_pos), .c(m1), .d(s_neg),
    .p(waste[1]), .q(lines[1]), .r(waste[2]), .s(lines[0])
  );

  always_comb begin
    // R1
    complement_chk: assert (lines[0] != lines[1])
      else $error("first stage lines not complementary");
  end
endmodule

// File: rtl/dualpol_decoder.sv
module dualpol_decoder #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]      code,
  input  logic              pol_low,
  output logic [(1<<N)-1:0] y,
  output logic [N+1:0]      junk
);
  import rgd_pkg::*;

  localparam int unsigned W   = 1 << N;
  localparam int unsigned TOT = total_lines(N);

  logic [W-1:0]   mcopy;
  logic [TOT-1:0] lines;

  rgd_copier #(.NC(W)) u_copier (
    .src(pol_low),
    .dup(mcopy)
  );

  rgd_core u_core (
    .sel0(code[0]),
    .m0(mcopy[0]),
    .m1(mcopy[1]),
    .lines(lines[1:0]),
    .waste(junk[2:0])
  );

  for (genvar k = 1; k < N; k++) begin : g_rank
    localparam int unsigned LW = 1 << k;
    localparam int unsigned IB = stage_base(k);
    localparam int unsigned OB = stage_base(k + 1);

    logic [LW:0] sel;
    assign sel[0] = code[k];

    for (genvar j = 0; j < LW; j++) begin : g_swap
      rgd_fredkin u_swap (
        .a(sel[j]),
        .b(lines[IB+j]),
        .c(mcopy[LW+j]),
        .p(sel[j+1]),
        .q(lines[OB+j]),
        .r(lines[OB+j+LW])
      );
    end

    assign junk[2+k] = sel[LW];
  end

  assign y = lines[TOT-1 -: W];

  always_comb begin
    // R1
    level_count_chk: assert ($countones(y) == (pol_low ? W - 1 : 1))
      else $error("wrong number of asserted lines");
    // R3
    picked_line_chk: assert (y[code] == !pol_low)
      else $error("selected line at wrong level");
  end
endmodule

// File: tb/test_dualpol_decoder.sv
module test_dualpol_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] c2, c3, c4;
  logic       p2, p3, p4;
  logic [3:0]  y2;
  logic [7:0]  y3;
  logic [15:0] y4;
  logic [3:0]  j2;
  logic [4:0]  j3;
  logic [5:0]  j4;

  dualpol_decoder #(.N(2)) i_dualpol_decoder_n2 (.code(c2[1:0]), .pol_low(p2), .y(y2), .junk(j2));
  dualpol_decoder #(.N(3)) i_dualpol_decoder_n3 (.code(c3[2:0]), .pol_low(p3), .y(y3), .junk(j3));
  dualpol_decoder #(.N(4)) i_dualpol_decoder    (.code(c4),      .pol_low(p4), .y(y4), .junk(j4));

  logic [1:0] fy_i; logic [1:0] fy_o;
  logic [2:0] f2_i; logic [2:0] f2_o;
  logic [3:0] bv_i; logic [3:0] bv_o;
  logic [2:0] fk_i; logic [2:0] fk_o;

  rgd_feynman  u_fy (.a(fy_i[1]), .b(fy_i[0]), .p(fy_o[1]), .q(fy_o[0]));
  rgd_dfeynman u_f2 (.a(f2_i[2]), .b(f2_i[1]), .c(f2_i[0]), .p(f2_o[2]), .q(f2_o[1]), .r(f2_o[0]));
  rgd_bvf      u_bv (.a(bv_i[3]), .b(bv_i[2]), .c(bv_i[1]), .d(bv_i[0]),
                     .p(bv_o[3]), .q(bv_o[2]), .r(bv_o[1]), .s(bv_o[0]));
  rgd_fredkin  u_fk (.a(fk_i[2]), .b(fk_i[1]), .c(fk_i[0]), .p(fk_o[2]), .q(fk_o[1]), .r(fk_o[0]));

  function automatic logic [15:0] model(input int n, input logic [3:0] cd, input logic pl);
    logic [15:0] oh;
    logic [15:0] mask;
    oh   = 16'(1) << cd;
    mask = 16'((32'd1 << (1 << n)) - 1);
    return (oh ^ {16{pl}}) & mask;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_dec(input int n, input logic [3:0] cd, input logic pl);
    @(negedge clk);
    case (n)
      2: begin c2 = cd & 4'h3; p2 = pl; end
      3: begin c3 = cd & 4'h7; p3 = pl; end
      default: begin c4 = cd; p4 = pl; end
    endcase
    #2;
  endtask

  function automatic logic [15:0] y_of(input int n);
    case (n)
      2: return {12'h0, y2};
      3: return {8'h0, y3};
      default: return y4;
    endcase
  endfunction

  function automatic string req_of(input int n, input logic pl);
    if (n != 4) return "R9";
    return pl ? "R2" : "R1";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [21:0] seen [32];
    logic [15:0] seen_mask;
    int dup_cnt;
    void'($urandom(32'd20240611));
    c2 = 0; c3 = 0; c4 = 0; p2 = 0; p3 = 0; p4 = 0;
    fy_i = 0; f2_i = 0; bv_i = 0; fk_i = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 initial state: code 0, active high
    check("R1", {16'h0, y4}, {16'h0, model(4, 4'd0, 1'b0)});
    rst = 1'b0;

    // R4 R7 controlled swap, full table and bijection
    seen_mask = 0;
    for (int v = 0; v < 8; v++) begin
      fk_i = 3'(v); #1;
      check("R4", {29'h0, fk_o}, {29'h0, fk_i[2] ? {fk_i[2], fk_i[0], fk_i[1]} : fk_i});
      seen_mask[fk_o] = 1'b1;
    end
    check("R7", {16'h0, seen_mask}, 32'h0000_00ff);

    // R5 R7 paired inverter
    seen_mask = 0;
    for (int v = 0; v < 16; v++) begin
      bv_i = 4'(v); #1;
      check("R5", {28'h0, bv_o},
            {28'h0, bv_i[3], bv_i[3] ^ bv_i[2], bv_i[1], bv_i[1] ^ bv_i[0]});
      seen_mask[bv_o] = 1'b1;
    end
    check("R7", {16'h0, seen_mask}, 32'h0000_ffff);

    // R6 R7 single and two-target inverters
    seen_mask = 0;
    for (int v = 0; v < 4; v++) begin
      fy_i = 2'(v); #1;
      check("R6", {30'h0, fy_o}, {30'h0, fy_i[1], fy_i[1] ^ fy_i[0]});
      seen_mask[fy_o] = 1'b1;
    end
    check("R7", {16'h0, seen_mask}, 32'h0000_000f);
    seen_mask = 0;
    for (int v = 0; v < 8; v++) begin
      f2_i = 3'(v); #1;
      check("R6", {29'h0, f2_o},
            {29'h0, f2_i[2], f2_i[2] ^ f2_i[1], f2_i[2] ^ f2_i[0]});
      seen_mask[f2_o] = 1'b1;
    end
    check("R7", {16'h0, seen_mask}, 32'h0000_00ff);

    // R3 directed: ordering with MSB at the top
    drive_dec(3, 4'd3, 1'b1);
    check("R3", {24'h0, y3}, 32'h0000_00f7);
    drive_dec(3, 4'd0, 1'b1);
    check("R3", {24'h0, y3}, 32'h0000_00fe);
    drive_dec(4, 4'd8, 1'b0);
    check("R3", {16'h0, y4}, 32'h0000_0100);

    // R1 R2 R9 exhaustive sweep for every size and polarity
    for (int n = 2; n <= 4; n++)
      for (int pl = 0; pl < 2; pl++)
        for (int cd = 0; cd < (1 << n); cd++) begin
          drive_dec(n, 4'(cd), 1'(pl));
          check(req_of(n, 1'(pl)), {16'h0, y_of(n)}, {16'h0, model(n, 4'(cd), 1'(pl))});
        end

    // R8 injectivity of the full N=4 map including junk
    for (int v = 0; v < 32; v++) begin
      drive_dec(4, 4'(v), 1'(v >> 4));
      seen[v] = {j4, y4};
    end
    dup_cnt = 0;
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        if (seen[a] == seen[b]) dup_cnt++;
    check("R8", dup_cnt, 0);

    // R1 R2 polarity flip with code held
    drive_dec(4, 4'd15, 1'b0);
    check("R1", {16'h0, y4}, 32'h0000_8000);
    drive_dec(4, 4'd15, 1'b1);
    check("R2", {16'h0, y4}, 32'h0000_7fff);

    // random mix across sizes
    for (int t = 0; t < 300; t++) begin
      int n;
      logic [3:0] cd;
      logic pl;
      n  = 2 + int'($urandom % 3);
      cd = 4'($urandom);
      pl = 1'($urandom);
      drive_dec(n, cd, pl);
      check(req_of(n, pl), {16'h0, y_of(n)},
            {16'h0, model(n, cd & 4'((1 << n) - 1), pl)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule